// File: doc/BRIEF.md
# Sector Transfer Segmenter with Bank Mapping

This block sits between a storage driver's request queue and a card host controller's command and data state machines. It accepts one request, made of a starting sector, a sector count and a direction, and walks through it chunk by chunk. For each chunk it waits until the card reports that it is ready for transfers. It then issues a multiple-block read or write command and programs the data path with a length, a control word and a timeout. After the data phase finishes and the transmit path has drained, it closes the chunk with a stop command.

A chunk is limited in two ways. Its byte length must fit a 16-bit length field, which caps it at `MAX_CHUNK` sectors. On a banked device it must also never run past the end of the current bank. On a banked device a fixed reserved area is skipped first by adding `RESERVED` to the start sector. The result is split into a bank number and an in-bank sector. A bank switch is requested only when the bank number differs from the bank last selected. Cards that are not high capacity receive byte addresses rather than sector addresses.

A chunk that ends with any data error is repeated in place. The request ends with a one-cycle `done` pulse carrying a result code.

Top module: `xfer_segmenter`

## Requirements
- R1: `req_ready` is high only while idle. A request is taken on a cycle with `req_valid && req_ready`. Each request ends with `done` high for exactly one cycle, with `done_code` 0 = success, 1 = range error, 2 = retry limit reached. No handshake output is active while `done` is high.
- R2: If `req_start + req_count > card_blocks`, the request finishes with code 1 and no bank, poll, command or data handshake is raised.
- R3: Every chunk holds between 1 and `MAX_CHUNK` sectors, and `dat_len` equals the chunk's sectors × 512.
- R4: On a banked device the working position is `req_start + RESERVED`. The bank is the position divided by `BANK_BLOCKS`, and the in-bank sector is the remainder. A chunk never extends past the end of its bank, and the chunks of a successful request cover the whole count in order.
- R5: A bank switch handshake (`bsw_valid` with `bsw_bank`) is raised before a chunk's status poll only when that chunk's bank differs from the bank last switched to (0 after reset). Completion of the switch makes the new bank current.
- R6: `cmd_arg` of the transfer command is the in-bank sector when `card_hc` is 1, and that sector × 512 when `card_hc` is 0.
- R7: `dat_ctrl` has bit 0 = 1 (enable), bit 1 = 1 for card-to-host (read), bit 2 = 0, bit 3 = 1 (DMA), and bits 7:4 = 9, giving 0x9B for reads and 0x99 for writes. `dat_timer` is `RD_TICKS` for reads and `WR_TICKS` for writes.
- R8: Each chunk runs in the order status poll, transfer command (index 18 read, 25 write), data phase (`dat_valid` held until `dat_end`), wait for `tx_active` low, and stop command (index 12, argument 0).
- R9: A chunk whose `dat_end` arrives with any `dat_err` bit set is repeated without advancing. The consecutive-failure count clears on each good chunk. The failure after `MAX_RETRY` consecutive failed attempts ends the request with code 2.
- R10: A request with a count of 0 that passes the range check finishes with code 0 and raises no handshake.
- R11: At most one of `bsw_valid`, `poll_valid`, `cmd_valid`, `dat_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_start | input | 32 | First sector of the request |
| req_count | input | 16 | Number of sectors |
| req_write | input | 1 | 1 = host-to-card, 0 = card-to-host |
| card_hc | input | 1 | Card is high capacity (sector addressing) |
| card_blocks | input | 32 | Usable sectors on the card |
| done | output | 1 | One-cycle end-of-request pulse |
| done_code | output | 2 | Result: 0 ok, 1 range, 2 retry limit |
| bsw_valid | output | 1 | Bank switch requested, held until `bsw_done` |
| bsw_bank | output | 8 | Bank to select |
| bsw_done | input | 1 | Bank switch finished |
| poll_valid | output | 1 | Wait-for-transfer-state requested, held until `poll_done` |
| poll_done | input | 1 | Card is in transfer state |
| cmd_valid | output | 1 | Command requested, held until `cmd_done` |
| cmd_index | output | 6 | Command index (18, 25 or 12) |
| cmd_arg | output | 32 | Command argument |
| cmd_done | input | 1 | Command completed |
| dat_valid | output | 1 | Data phase programmed, held until `dat_end` |
| dat_len | output | 16 | Data length in bytes |
| dat_ctrl | output | 8 | Data control word |
| dat_timer | output | 32 | Data timeout in peripheral-clock cycles |
| dat_end | input | 1 | Data phase ended (good or failed) |
| dat_err | input | 5 | Error flags valid with `dat_end`: CRC, timeout, underrun, overrun, start bit |
| tx_active | input | 1 | Transmit path still busy |

## Verification
The properties assume well-behaved completion inputs: each `*_done` and `dat_end` comes as a single-cycle pulse only while its own request is high, and `tx_active` falls a bounded time after `dat_end`. They also assume `req_count` never drives a chunk length to zero. The bench's responder holds every completion two cycles after it first sees the request. It pulses the completion once and raises `tx_active` only after a data phase, for three cycles. It therefore never answers a request that is not pending. Requests sweep start and count across several small banks. Some pass the card limit on purpose, and error injection is scripted per data phase.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_MAP, S_BANK, S_POLL, S_CMD, S_DATA, S_DRAIN, S_STOP, S_UPDATE, S_DONE
  } seg_state_e;

  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_RANGE = 2'd1,
    RES_FATAL = 2'd2
  } seg_result_e;

  localparam logic [5:0] CMD_RD_MULTI = 6'd18;
  localparam logic [5:0] CMD_WR_MULTI = 6'd25;
  localparam logic [5:0] CMD_STOP     = 6'd12;
  localparam int unsigned BLK_LOG2    = 9;
endpackage

// File: rtl/seg_addr_map.sv
module seg_addr_map #(
  parameter int unsigned SEC_W       = 32,
  parameter int unsigned BANK_W      = 8,
  parameter bit          BANKED      = 1'b1,
  parameter int unsigned BANK_BLOCKS = 32'h7A7800
) (
  input  logic [SEC_W-1:0]  pos,
  input  logic              hc,
  output logic [BANK_W-1:0] bank,
  output logic [SEC_W-1:0]  offset,
  output logic [SEC_W-1:0]  arg
);
  import seg_pkg::*;

  localparam logic [SEC_W-1:0] SPAN = SEC_W'(BANK_BLOCKS);

  if (BANKED) begin : g_banked
    logic [SEC_W-1:0] quot;
    assign quot   = pos / SPAN;
    assign bank   = BANK_W'(quot);
    assign offset = pos % SPAN;
  end else begin : g_flat
    assign bank   = '0;
    assign offset = pos;
  end

  // sector addressing for high-capacity cards, byte addressing otherwise
  assign arg = hc ? offset : (offset << BLK_LOG2);
endmodule

// File: rtl/seg_chunk_size.sv
module seg_chunk_size #(
  parameter int unsigned SEC_W       = 32,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned MAX_CHUNK   = 127,
  parameter bit          BANKED      = 1'b1,
  parameter int unsigned BANK_BLOCKS = 32'h7A7800
) (
  input  logic [CNT_W-1:0] remain,
  input  logic [SEC_W-1:0] offset,
  output logic [CNT_W-1:0] chunk
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_CHUNK);

  logic [CNT_W-1:0] capped;
  assign capped = (remain > CAP) ? CAP : remain;

  if (BANKED) begin : g_bank_cut
    logic [SEC_W-1:0] room;
    assign room  = SEC_W'(BANK_BLOCKS) - offset;
    assign chunk = (SEC_W'(capped) > room) ? CNT_W'(room) : capped;
  end else begin : g_no_cut
    logic unused_off;
    assign unused_off = ^offset;
    assign chunk = capped;
  end
endmodule

// File: rtl/seg_retry_ctr.sv
module seg_retry_ctr #(
  parameter int unsigned MAX_RETRY = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic exhausted
);
  localparam int unsigned CW = $clog2(MAX_RETRY + 1) + 1;

  logic [CW-1:0] fails;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fails <= '0;
    else if (clear)  fails <= '0;
    else if (bump)   fails <= fails + 1'b1;
  end

  assign exhausted = (fails == CW'(MAX_RETRY));
endmodule

// File: rtl/xfer_segmenter.sv
module xfer_segmenter #(
  parameter int unsigned SEC_W       = 32,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned BANK_W      = 8,
  parameter int unsigned TMR_W       = 32,
  parameter bit          BANKED      = 1'b1,
  parameter int unsigned BANK_BLOCKS = 32'h7A7800,
  parameter int unsigned RESERVED    = 32'h2000,
  parameter int unsigned MAX_CHUNK   = 127,
  parameter int unsigned MAX_RETRY   = 10,
  parameter int unsigned PCLK_HZ     = 62_000_000,
  parameter int unsigned RD_TICKS    = PCLK_HZ / 1000 * 100,
  parameter int unsigned WR_TICKS    = PCLK_HZ / 1000 * 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEC_W-1:0]  req_start,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              req_write,
  input  logic              card_hc,
  input  logic [SEC_W-1:0]  card_blocks,
  output logic              done,
  output logic [1:0]        done_code,
  output logic              bsw_valid,
  output logic [BANK_W-1:0] bsw_bank,
  input  logic              bsw_done,
  output logic              poll_valid,
  input  logic              poll_done,
  output logic              cmd_valid,
  output logic [5:0]        cmd_index,
  output logic [SEC_W-1:0]  cmd_arg,
  input  logic              cmd_done,
  output logic              dat_valid,
  output logic [15:0]       dat_len,
  output logic [7:0]        dat_ctrl,
  output logic [TMR_W-1:0]  dat_timer,
  input  logic              dat_end,
  input  logic [4:0]        dat_err,
  input  logic              tx_active
);
  import seg_pkg::*;

  localparam logic [SEC_W-1:0] SKIP = BANKED ? SEC_W'(RESERVED) : '0;
  localparam int unsigned      LEN_W = 16;

  seg_state_e        state;
  logic [SEC_W-1:0]  pos_r;
  logic [CNT_W-1:0]  cnt_r;
  logic [CNT_W-1:0]  chunk_r;
  logic [BANK_W-1:0] bank_r;
  logic [BANK_W-1:0] cur_bank_r;
  logic [SEC_W-1:0]  arg_r;
  logic              wr_r;
  logic              hc_r;
  logic              fail_r;
  logic [1:0]        code_r;

  logic [BANK_W-1:0] map_bank;
  logic [SEC_W-1:0]  map_off;
  logic [SEC_W-1:0]  map_arg;
  logic [CNT_W-1:0]  map_chunk;
  logic              out_of_range;
  logic              retry_clear;
  logic              retry_bump;
  logic              retry_full;

  seg_addr_map #(
    .SEC_W(SEC_W), .BANK_W(BANK_W), .BANKED(BANKED), .BANK_BLOCKS(BANK_BLOCKS)
  ) u_map (
    .pos(pos_r), .hc(hc_r), .bank(map_bank), .offset(map_off), .arg(map_arg)
  );

  seg_chunk_size #(
    .SEC_W(SEC_W), .CNT_W(CNT_W), .MAX_CHUNK(MAX_CHUNK),
    .BANKED(BANKED), .BANK_BLOCKS(BANK_BLOCKS)
  ) u_size (
    .remain(cnt_r), .offset(map_off), .chunk(map_chunk)
  );

  seg_retry_ctr #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk(clk), .rst_n(rst_n), .clear(retry_clear), .bump(retry_bump),
    .exhausted(retry_full)
  );

  assign out_of_range = ({1'b0, req_start} + (SEC_W+1)'(req_count)) > {1'b0, card_blocks};

  assign retry_clear = (state == S_IDLE) || (state == S_UPDATE && !fail_r);
  assign retry_bump  = (state == S_UPDATE) && fail_r && !retry_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      pos_r      <= '0;
      cnt_r      <= '0;
      chunk_r    <= '0;
      bank_r     <= '0;
      cur_bank_r <= '0;
      arg_r      <= '0;
      wr_r       <= 1'b0;
      hc_r       <= 1'b0;
      fail_r     <= 1'b0;
      code_r     <= RES_OK;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          pos_r <= req_start + SKIP;
          cnt_r <= req_count;
          wr_r  <= req_write;
          hc_r  <= card_hc;
          if (out_of_range) begin
            code_r <= RES_RANGE;
            state  <= S_DONE;
          end else if (req_count == '0) begin
            code_r <= RES_OK;
            state  <= S_DONE;
          end else begin
            state <= S_MAP;
          end
        end
        S_MAP: begin
          bank_r  <= map_bank;
          chunk_r <= map_chunk;
          arg_r   <= map_arg;
          state   <= (BANKED && map_bank != cur_bank_r) ? S_BANK : S_POLL;
        end
        S_BANK: if (bsw_done) begin
          cur_bank_r <= bank_r;
          state      <= S_POLL;
        end
        S_POLL:  if (poll_done) state <= S_CMD;
        S_CMD:   if (cmd_done)  state <= S_DATA;
        S_DATA: if (dat_end) begin
          fail_r <= |dat_err;
          state  <= S_DRAIN;
        end
        S_DRAIN: if (!tx_active) state <= S_STOP;
        S_STOP:  if (cmd_done)   state <= S_UPDATE;
        S_UPDATE: begin
          if (!fail_r) begin
            pos_r <= pos_r + SEC_W'(chunk_r);
            cnt_r <= cnt_r - chunk_r;
            if (cnt_r == chunk_r) begin
              code_r <= RES_OK;
              state  <= S_DONE;
            end else begin
              state <= S_MAP;
            end
          end else if (retry_full) begin
            code_r <= RES_FATAL;
            state  <= S_DONE;
          end else begin
            state <= S_MAP;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == S_IDLE);
  assign done       = (state == S_DONE);
  assign done_code  = code_r;

  assign bsw_valid  = (state == S_BANK);
  assign bsw_bank   = bank_r;
  assign poll_valid = (state == S_POLL);

  assign cmd_valid  = (state == S_CMD) || (state == S_STOP);
  assign cmd_index  = (state == S_STOP) ? CMD_STOP : (wr_r ? CMD_WR_MULTI : CMD_RD_MULTI);
  assign cmd_arg    = (state == S_STOP) ? '0 : arg_r;

  assign dat_valid  = (state == S_DATA);
  assign dat_len    = LEN_W'({chunk_r, {BLK_LOG2{1'b0}}});
  assign dat_ctrl   = {4'(BLK_LOG2), 1'b1, 1'b0, ~wr_r, 1'b1};
  assign dat_timer  = wr_r ? TMR_W'(WR_TICKS) : TMR_W'(RD_TICKS);
endmodule

// File: rtl/seg_checker.sv
module seg_checker #(
  parameter int unsigned MAX_CHUNK = 127
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        done,
  input logic        bsw_valid,
  input logic        poll_valid,
  input logic        cmd_valid,
  input logic [5:0]  cmd_index,
  input logic [31:0] cmd_arg,
  input logic        dat_valid,
  input logic [15:0] dat_len,
  input logic [7:0]  dat_ctrl,
  input logic        dat_end,
  input logic        tx_active
);
  localparam logic [15:0] LEN_CAP = 16'(MAX_CHUNK * 512);

  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid |-> (dat_len != 16'd0 && dat_len <= LEN_CAP && dat_len[8:0] == 9'd0)); // R3

  AST_CTRL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid |-> (dat_ctrl[0] && dat_ctrl[3] && !dat_ctrl[2] && dat_ctrl[7:4] == 4'd9)); // R7

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bsw_valid, poll_valid, cmd_valid, dat_valid})); // R11

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R1

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(bsw_valid || poll_valid || cmd_valid || dat_valid || req_ready)); // R1

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R1

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_index == 6'd12) |-> (!tx_active && cmd_arg == 32'd0)); // R8

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && !dat_end) |=> dat_valid); // R8
endmodule

bind xfer_segmenter seg_checker #(.MAX_CHUNK(MAX_CHUNK)) u_chk (.*);

// File: tb/sim_xfer_segmenter.sv
module sim_xfer_segmenter;
  localparam int BB   = 20;
  localparam int RES  = 3;
  localparam int MC   = 7;
  localparam int CARD = 50;
  localparam int RDT  = 100;
  localparam int WRT  = 250;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, card_hc = 1'b0;
  logic [31:0] req_start = '0;
  logic [15:0] req_count = '0;
  logic [31:0] card_blocks = 32'(CARD);
  logic        req_ready, done;
  logic [1:0]  done_code;
  logic        bsw_valid, poll_valid, cmd_valid, dat_valid;
  logic [7:0]  bsw_bank;
  logic [5:0]  cmd_index;
  logic [31:0] cmd_arg;
  logic [15:0] dat_len;
  logic [7:0]  dat_ctrl;
  logic [31:0] dat_timer;
  logic        bsw_done = 0, poll_done = 0, cmd_done = 0, dat_end = 0, tx_active = 0;
  logic [4:0]  dat_err = '0;

  always #10 clk = ~clk;

  xfer_segmenter #(
    .BANK_BLOCKS(BB), .RESERVED(RES), .MAX_CHUNK(MC), .RD_TICKS(RDT), .WR_TICKS(WRT)
  ) u0 (.*);

  int checks = 0, fails = 0;
  bit finished = 0;

  // expected chunk plan
  int exp_bank [64];
  bit exp_sw   [64];
  int exp_arg  [64];
  int exp_len  [64];
  int nch = 0, ptr = 0, cur_bank_m = 0, events = 0;
  bit sw_seen = 0, poll_seen = 0, cur_wr = 0, cur_fail = 0;
  int inj_left = 0, inj_reload = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic plan(input int start, input int count, input bit hc);
    int pos, left, bank, off, n, cb;
    nch = 0;
    if (start + count > CARD) return;
    pos = start + RES; left = count; cb = cur_bank_m;
    while (left > 0) begin
      bank = pos / BB; off = pos % BB;
      n = (left > MC) ? MC : left;
      if (n > BB - off) n = BB - off;
      exp_bank[nch] = bank;
      exp_sw[nch]   = (bank != cb);
      cb            = bank;
      exp_arg[nch]  = hc ? off : off * 512;
      exp_len[nch]  = n * 512;
      nch++; pos += n; left -= n;
    end
  endtask

  // responder: samples and drives at the falling edge
  initial begin
    bit busy = 0; int dly = 0; int kind = 0; int txc = 0;
    forever begin
      @(negedge clk);
      bsw_done = 0; poll_done = 0; cmd_done = 0; dat_end = 0; dat_err = '0;
      if (txc > 0) begin txc--; if (txc == 0) tx_active = 0; end
      if (!busy && rst_n) begin
        if (bsw_valid) begin
          events++; kind = 1;
          chk(ptr < nch && exp_sw[ptr] && !sw_seen, "R5 unexpected bank switch", ptr, nch);
          if (ptr < nch) chk(int'(bsw_bank) == exp_bank[ptr], "R4 bank number", bsw_bank, exp_bank[ptr]);
          cur_bank_m = bsw_bank; sw_seen = 1;
        end else if (poll_valid) begin
          events++; kind = 2; poll_seen = 1;
          chk(ptr < nch, "R2 poll outside plan", ptr, nch);
          if (ptr < nch) chk(!exp_sw[ptr] || sw_seen, "R5 missing bank switch", sw_seen, 1);
        end else if (cmd_valid && cmd_index != 6'd12) begin
          events++; kind = 3;
          chk(poll_seen, "R8 command before poll", poll_seen, 1);
          chk(cmd_index == (cur_wr ? 6'd25 : 6'd18), "R8 command index", cmd_index, cur_wr ? 25 : 18);
          if (ptr < nch) chk(int'(cmd_arg) == exp_arg[ptr], "R6 command argument", cmd_arg, exp_arg[ptr]);
        end else if (dat_valid) begin
          events++; kind = 4;
          if (ptr < nch) chk(int'(dat_len) == exp_len[ptr], "R3 R4 data length", dat_len, exp_len[ptr]);
          chk(dat_ctrl == (cur_wr ? 8'h99 : 8'h9B), "R7 control word", dat_ctrl, cur_wr ? 8'h99 : 8'h9B);
          chk(int'(dat_timer) == (cur_wr ? WRT : RDT), "R7 data timeout", dat_timer, cur_wr ? WRT : RDT);
        end else if (cmd_valid) begin
          events++; kind = 5;
          chk(!tx_active, "R8 stop while transmit busy", tx_active, 0);
          chk(cmd_arg == 0, "R8 stop argument", cmd_arg, 0);
        end else kind = 0;
        if (kind != 0) begin busy = 1; dly = 2; end
      end else if (busy) begin
        dly--;
        if (dly == 0) begin
          busy = 0;
          case (kind)
            1: bsw_done = 1;
            2: poll_done = 1;
            3: cmd_done = 1;
            5: cmd_done = 1;
            4: begin
              dat_end = 1; tx_active = 1; txc = 3;
              if (inj_left > 0) begin
                dat_err = 5'(1 << (inj_left % 5)); inj_left--; cur_fail = 1;
              end else begin
                cur_fail = 0; ptr++; sw_seen = 0;
                if (inj_reload > 0) begin inj_left = inj_reload; inj_reload = 0; end
              end
              poll_seen = 0;
            end
            default: ;
          endcase
        end
      end
    end
  end

  task automatic run(input int start, input int count, input bit wr, input bit hc,
                     input int exp_code, input string tag);
    int wait_cyc = 0;
    plan(start, count, hc);
    ptr = 0; events = 0; sw_seen = 0; poll_seen = 0; cur_wr = wr;
    @(negedge clk);
    req_start = 32'(start); req_count = 16'(count); req_write = wr; card_hc = hc;
    chk(req_ready, "R1 ready while idle", req_ready, 1);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (!done && wait_cyc < 20000) begin @(negedge clk); wait_cyc++; end
    chk(done, {tag, " done seen"}, done, 1);
    chk(int'(done_code) == exp_code, {tag, " result code"}, done_code, exp_code);
    if (exp_code == 0) chk(ptr == nch, "R4 chunks covered", ptr, nch);
    if (exp_code == 1 || count == 0) chk(events == 0, {tag, " no handshake"}, events, 0);
    @(negedge clk);
    chk(!done, "R1 done single cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !bsw_valid && !poll_valid && !cmd_valid && !dat_valid,
        "R1 reset state", {req_ready, done, bsw_valid, poll_valid, cmd_valid, dat_valid}, 6'b100000);
    rst_n = 1;
    // near-exhaustive sweep of start/count, both addressing modes
    for (int hc = 0; hc < 2; hc++)
      for (int s = 0; s < 50; s += 3)
        for (int c = 0; c <= 20; c++)
          run(s, c, bit'((s + c) & 1), bit'(hc),
              (s + c > CARD) ? 1 : 0, (s + c > CARD) ? "R2" : (c == 0 ? "R10" : "R4"));
    // exact upper limit and one past it
    run(40, 10, 0, 0, 0, "R2 at limit");
    run(41, 10, 1, 1, 1, "R2 past limit");
    // retries: ten failures then success on a chunk
    inj_left = 10; run(14, 12, 0, 1, 0, "R9 ten retries");
    // counter clears after a good chunk
    inj_left = 10; inj_reload = 10; run(2, 20, 1, 0, 0, "R9 counter clears");
    // eleventh consecutive failure is fatal
    inj_left = 11; run(5, 6, 0, 0, 2, "R9 fatal");
    inj_left = 0;
    run(5, 6, 0, 0, 0, "R9 recovers after fatal");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule